// File: doc/BRIEF.md
# PCI Bus Phase Classifier

This block listens to a 32-bit PCI bus on the bus clock and never drives it. It keeps a copy of FRAME# that is one clock late. From that copy and the live control lines it puts every bus clock into one kind:

- a transaction's opening (address/command) clock
- the opening clock of a configuration access
- a completed data transfer
- a target stop or retry
- the final clock of a master abort
- none of these, which covers wait states and idle clocks

A trace buffer or an event counter sits behind it. The block hands it only the clocks selected by a store mask, so wait states never use up storage.

For each selected clock the block raises a strobe for one cycle. With it comes a record holding:

- the AD and C/BE# values seen on that clock
- a phase code
- the value of a clock counter that runs freely from reset

Separately, the block counts the completed transfers since the last opening clock. It reports that count, with a one-cycle valid pulse, when the next transaction opens.

Top module: `pci_phase_tap`

## Requirements
- R1: The late copy of FRAME# is FRAME# sampled at each rising edge. A clock is an address phase when FRAME# is low and the late copy is still high. So only the first clock of a transaction counts as an address phase, even when FRAME# stays low through a burst.
- R2: An address phase whose C/BE#[3:1] equals 3'b101 is a configuration address phase, and its phase code is 2. It outranks the plain address code 1.
- R3: A clock with IRDY# and TRDY# both low is a data phase, with phase code 3.
- R4: A clock with IRDY# and STOP# both low is a stop/retry term, with phase code 4.
- R5: A clock with FRAME# high, DEVSEL# high and IRDY# low is a master-abort end, with phase code 5.
- R6: The storeMask bits enable the terms as follows:
  - bit 0: address phase
  - bit 1: configuration address phase
  - bit 2: data phase
  - bit 3: stop/retry
  - bit 4: master-abort end

  The strobe is the OR of the matching terms that are enabled. The phase code is that of the highest-priority enabled match, in the order config, address, data, stop, master-abort end.
- R7: A clock that matches no enabled term, such as a wait state or an idle clock, raises no strobe.
- R8: The strobe is high for exactly the one cycle after the classified bus clock. With it, the record shows that clock's AD, C/BE# and timestamp. The timestamp is the number of clocks since reset was released, starting at 0.
- R9: A transfer counter is cleared by each address phase and steps on each data phase, whatever the mask is set to. At every address phase, burstLen takes the count accumulated up to that clock, and burstValid pulses for one cycle.
- R10: While the active-low synchronous reset is held, the late FRAME# copy is set high and both counters are cleared. storeStb, burstValid and recPhase stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| frameN | input | 1 | FRAME# observed on the bus |
| irdyN | input | 1 | IRDY# observed |
| trdyN | input | 1 | TRDY# observed |
| stopN | input | 1 | STOP# observed |
| devselN | input | 1 | DEVSEL# observed |
| ad | input | 32 | AD bus observed |
| cbeN | input | 4 | C/BE# observed |
| storeMask | input | 5 | Selects which terms raise the strobe |
| storeStb | output | 1 | One-cycle strobe for a stored clock |
| recAd | output | 32 | Captured AD |
| recCbe | output | 4 | Captured C/BE# |
| recPhase | output | 3 | Phase code of the stored clock |
| recTime | output | 32 | Clock count of the stored clock |
| burstLen | output | 16 | Transfers in the previous transaction |
| burstValid | output | 1 | burstLen updated this cycle |

## Verification
Three cases are hard to reach from the ports, and the bench drives each one with its own directed cycle sequence.

The first is an address phase on the very first clock after reset, with FRAME# held low throughout reset. Only the reset value of the late FRAME# copy can flag that clock as an address phase. The bench asserts reset with FRAME# low and releases it at the same negative edge on which the first bus clock is driven.

The second is a disconnect clock, where data and stop terms match together. The bench runs it under masks that differ only in the data enable, so the phase code shows the priority rule.

The third is a burst length taken across a reset. The bench issues data clocks, resets, and then opens a transaction, and expects a count of 0.

// File: rtl/pci_tap_pkg.sv
package pci_tap_pkg;

  localparam int MASK_W   = 5;
  localparam int BIT_ADDR = 0;
  localparam int BIT_CFG  = 1;
  localparam int BIT_DATA = 2;
  localparam int BIT_STOP = 3;
  localparam int BIT_MAB  = 4;

  typedef enum logic [2:0] {
    PH_WAIT   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_CFG    = 3'd2,
    PH_DATA   = 3'd3,
    PH_STOP   = 3'd4,
    PH_MABORT = 3'd5
  } phase_e;

  typedef struct packed {
    logic   store;
    logic   addrSeen;
    logic   dataSeen;
    phase_e code;
  } ctlStb_t;

endpackage

// File: rtl/pci_tap_ctrl.sv
module pci_tap_ctrl
  import pci_tap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic              trdyN,
  input  logic              stopN,
  input  logic              devselN,
  input  logic [2:0]        cmdHiN,
  input  logic [MASK_W-1:0] storeMask,
  output ctlStb_t           ctl
);

  localparam logic [2:0] CFG_CMD_HI = 3'b101;

  logic              dframeN;
  logic              pastValid;
  logic [MASK_W-1:0] hitVec;
  logic [MASK_W-1:0] enVec;
  phase_e            code;

  // One-clock-late FRAME#, deasserted after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dframeN   <= 1'b1;
      pastValid <= 1'b0;
    end else begin
      dframeN   <= frameN;
      pastValid <= 1'b1;
    end
  end

  always_comb begin
    hitVec           = '0;
    hitVec[BIT_ADDR] = !frameN && dframeN;
    hitVec[BIT_CFG]  = !frameN && dframeN && (cmdHiN == CFG_CMD_HI);
    hitVec[BIT_DATA] = !irdyN && !trdyN;
    hitVec[BIT_STOP] = !irdyN && !stopN;
    hitVec[BIT_MAB]  = frameN && devselN && !irdyN;
  end

  assign enVec = hitVec & storeMask;

  // Priority: config, address, data, stop, master-abort end
  always_comb begin
    if (enVec[BIT_CFG])       code = PH_CFG;
    else if (enVec[BIT_ADDR]) code = PH_ADDR;
    else if (enVec[BIT_DATA]) code = PH_DATA;
    else if (enVec[BIT_STOP]) code = PH_STOP;
    else if (enVec[BIT_MAB])  code = PH_MABORT;
    else                      code = PH_WAIT;
  end

  always_comb begin
    ctl.store    = |enVec;
    ctl.addrSeen = hitVec[BIT_ADDR];
    ctl.dataSeen = hitVec[BIT_DATA];
    ctl.code     = code;
  end

  AST_ADDR_FIRST_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ctl.addrSeen) |-> $past(frameN)); // R1

  AST_CFG_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.code == PH_CFG) |-> (ctl.addrSeen && cmdHiN == CFG_CMD_HI && storeMask[BIT_CFG])); // R2

endmodule

// File: rtl/pci_tap_dp.sv
module pci_tap_dp
  import pci_tap_pkg::*;
#(
  parameter int AD_W    = 32,
  parameter int CBE_W   = 4,
  parameter int TS_W    = 32,
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStb_t            ctl,
  input  logic [AD_W-1:0]    ad,
  input  logic [CBE_W-1:0]   cbeN,
  input  logic [MASK_W-1:0]  storeMask,
  output logic               storeStb,
  output logic [AD_W-1:0]    recAd,
  output logic [CBE_W-1:0]   recCbe,
  output logic [2:0]         recPhase,
  output logic [TS_W-1:0]    recTime,
  output logic [BURST_W-1:0] burstLen,
  output logic               burstValid
);

  localparam logic [TS_W-1:0]    TS_ONE    = {{(TS_W-1){1'b0}}, 1'b1};
  localparam logic [BURST_W-1:0] BURST_ONE = {{(BURST_W-1){1'b0}}, 1'b1};

  logic [TS_W-1:0]    tsCnt;
  logic [BURST_W-1:0] burstCnt;

  always_ff @(posedge clk) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + TS_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeStb <= 1'b0;
      recAd    <= '0;
      recCbe   <= '0;
      recPhase <= PH_WAIT;
      recTime  <= '0;
    end else begin
      storeStb <= ctl.store;
      if (ctl.store) begin
        recAd    <= ad;
        recCbe   <= cbeN;
        recPhase <= ctl.code;
        recTime  <= tsCnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstCnt   <= '0;
      burstLen   <= '0;
      burstValid <= 1'b0;
    end else begin
      burstValid <= ctl.addrSeen;
      if (ctl.addrSeen) begin
        burstLen <= burstCnt;
        burstCnt <= '0;
      end else if (ctl.dataSeen) begin
        burstCnt <= burstCnt + BURST_ONE;
      end
    end
  end

  AST_STB_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    storeStb |-> ($past(storeMask) != '0)); // R6

  AST_STB_NOT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    storeStb |-> (recPhase != PH_WAIT)); // R7

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (storeStb && $past(storeStb)) |-> (recTime == $past(recTime) + TS_ONE)); // R8

  AST_BURST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |=> !burstValid); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!storeStb && !burstValid)); // R10

endmodule

// File: rtl/pci_phase_tap.sv
module pci_phase_tap
  import pci_tap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        trdyN,
  input  logic        stopN,
  input  logic        devselN,
  input  logic [31:0] ad,
  input  logic [3:0]  cbeN,
  input  logic [4:0]  storeMask,
  output logic        storeStb,
  output logic [31:0] recAd,
  output logic [3:0]  recCbe,
  output logic [2:0]  recPhase,
  output logic [31:0] recTime,
  output logic [15:0] burstLen,
  output logic        burstValid
);

  ctlStb_t ctl;

  pci_tap_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameN    (frameN),
    .irdyN     (irdyN),
    .trdyN     (trdyN),
    .stopN     (stopN),
    .devselN   (devselN),
    .cmdHiN    (cbeN[3:1]),
    .storeMask (storeMask),
    .ctl       (ctl)
  );

  pci_tap_dp #(
    .AD_W    (32),
    .CBE_W   (4),
    .TS_W    (32),
    .BURST_W (16)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .ad         (ad),
    .cbeN       (cbeN),
    .storeMask  (storeMask),
    .storeStb   (storeStb),
    .recAd      (recAd),
    .recCbe     (recCbe),
    .recPhase   (recPhase),
    .recTime    (recTime),
    .burstLen   (burstLen),
    .burstValid (burstValid)
  );

endmodule

// File: tb/pci_phase_tap_tb.sv
module pci_phase_tap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] M_ALL = 5'b11111;

  typedef struct {
    logic        stb;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic [2:0]  code;
    logic [31:0] tm;
    logic        bv;
    logic [15:0] bl;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1, stopN = 1'b1, devselN = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbeN = 4'hF;
  logic [4:0]  storeMask = M_ALL;
  logic        storeStb, burstValid;
  logic [31:0] recAd, recTime;
  logic [3:0]  recCbe;
  logic [2:0]  recPhase;
  logic [15:0] burstLen;

  int testsRun = 0;
  int testsFailed = 0;
  exp_t expQ[$];
  logic [31:0] tbCyc = '0;
  logic        mPrevFrame = 1'b1;
  logic [15:0] mBurst = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_phase_tap dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .stopN(stopN), .devselN(devselN), .ad(ad), .cbeN(cbeN), .storeMask(storeMask),
    .storeStb(storeStb), .recAd(recAd), .recCbe(recCbe), .recPhase(recPhase),
    .recTime(recTime), .burstLen(burstLen), .burstValid(burstValid)
  );

  always @(posedge clk) begin
    if (!rstN) tbCyc <= '0;
    else       tbCyc <= tbCyc + 32'd1;
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: drives one bus clock and pushes the expected outcome
  task automatic busCycle(input logic f, input logic i, input logic t, input logic s,
                          input logic d, input logic [31:0] a, input logic [3:0] c,
                          input logic [4:0] m, input string tag);
    exp_t e;
    logic addr, cfg, dat, stp, mab;
    logic [4:0] en;
    @(negedge clk);
    rstN = 1'b1;
    frameN = f; irdyN = i; trdyN = t; stopN = s; devselN = d;
    ad = a; cbeN = c; storeMask = m;
    addr = !f && mPrevFrame;
    cfg  = addr && (c[3:1] == 3'b101);
    dat  = !i && !t;
    stp  = !i && !s;
    mab  = f && d && !i;
    en   = {mab, stp, dat, cfg, addr} & m;
    e.stb = |en;
    if (en[1])      e.code = 3'd2;
    else if (en[0]) e.code = 3'd1;
    else if (en[2]) e.code = 3'd3;
    else if (en[3]) e.code = 3'd4;
    else if (en[4]) e.code = 3'd5;
    else            e.code = 3'd0;
    e.ad = a; e.cbe = c; e.tm = tbCyc; e.tag = tag;
    e.bv = addr; e.bl = mBurst;
    if (addr)     mBurst = '0;
    else if (dat) mBurst = mBurst + 16'd1;
    mPrevFrame = f;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    busCycle(1, 1, 1, 1, 1, 32'h0, 4'hF, M_ALL, tag);
  endtask

  // Monitor: pops and compares one expected item per clock
  always @(posedge clk) begin
    #1;
    if (rstN && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, "storeStb", {31'b0, storeStb}, {31'b0, e.stb});
      if (e.stb && storeStb) begin
        check(e.tag, "recAd", recAd, e.ad);
        check(e.tag, "recCbe", {28'b0, recCbe}, {28'b0, e.cbe});
        check(e.tag, "recPhase", {29'b0, recPhase}, {29'b0, e.code});
        check(e.tag, "recTime (R8)", recTime, e.tm);
      end
      check("R9", "burstValid", {31'b0, burstValid}, {31'b0, e.bv});
      if (e.bv) check("R9", "burstLen", {16'b0, burstLen}, {16'b0, e.bl});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    testsFailed++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "storeStb in reset", {31'b0, storeStb}, 32'd0);
    check("R10", "burstValid in reset", {31'b0, burstValid}, 32'd0);
    check("R10", "recPhase in reset", {29'b0, recPhase}, 32'd0);

    // Memory write burst with a wait state
    idle("R7");
    busCycle(0, 1, 1, 1, 1, 32'h000A18D0, 4'b0111, M_ALL, "R1");
    busCycle(0, 0, 0, 1, 0, 32'hABCD0000, 4'b0011, M_ALL, "R3");
    busCycle(0, 0, 1, 1, 0, 32'h11111111, 4'b0000, M_ALL, "R7");
    busCycle(0, 0, 0, 1, 0, 32'hABCDABCD, 4'b0000, M_ALL, "R3");
    busCycle(1, 0, 0, 1, 0, 32'h0000ABCD, 4'b1100, M_ALL, "R3");
    idle("R7");
    // Second transaction reports the previous burst length of 3
    busCycle(0, 1, 1, 1, 1, 32'h000A18D8, 4'b0111, M_ALL, "R1");
    busCycle(1, 0, 0, 1, 0, 32'h12345678, 4'b0000, M_ALL, "R3");
    idle("R7");

    // I/O read answered with a retry
    busCycle(0, 1, 1, 1, 1, 32'h00000064, 4'b0010, M_ALL, "R1");
    busCycle(1, 0, 1, 1, 1, 32'h0, 4'b1110, M_ALL, "R7");
    busCycle(1, 0, 1, 0, 0, 32'h0, 4'b1110, M_ALL, "R4");
    idle("R7");

    // Config read that master-aborts
    busCycle(0, 1, 1, 1, 1, 32'h80000000, 4'b1010, M_ALL, "R2");
    busCycle(1, 0, 1, 1, 1, 32'h40000000, 4'b1010, M_ALL, "R5");
    idle("R7");

    // Mask behaviour: config term disabled, data disabled, disconnect priority
    busCycle(0, 1, 1, 1, 1, 32'h10000000, 4'b1011, 5'b11101, "R6");
    busCycle(0, 0, 0, 1, 0, 32'h3206100C, 4'b0000, 5'b11011, "R6");
    busCycle(1, 0, 0, 0, 0, 32'hCAFEF00D, 4'b0000, M_ALL, "R6");
    idle("R7");
    busCycle(0, 1, 1, 1, 1, 32'h20000000, 4'b0110, M_ALL, "R1");
    busCycle(1, 0, 0, 0, 0, 32'hDEADBEEF, 4'b0000, 5'b11011, "R6");
    idle("R7");
    // Mask of zero: nothing stored, burst count still latched
    busCycle(0, 1, 1, 1, 1, 32'h30000000, 4'b0111, 5'b00000, "R6");
    busCycle(1, 0, 0, 1, 0, 32'h5, 4'b0000, 5'b00000, "R7");
    busCycle(1, 1, 1, 1, 1, 32'h0, 4'hF, 5'b00000, "R7");

    // Data clocks, then reset with FRAME# low, then an address phase
    busCycle(1, 0, 0, 1, 0, 32'h7, 4'b0000, M_ALL, "R3");
    busCycle(1, 0, 0, 1, 0, 32'h8, 4'b0000, M_ALL, "R3");
    @(negedge clk);
    rstN = 1'b0; frameN = 1'b0; irdyN = 1'b1; trdyN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10", "storeStb in reset", {31'b0, storeStb}, 32'd0);
    check("R10", "burstValid in reset", {31'b0, burstValid}, 32'd0);
    mPrevFrame = 1'b1;
    mBurst = '0;
    busCycle(0, 1, 1, 1, 1, 32'h000A0004, 4'b0111, M_ALL, "R10");
    busCycle(0, 1, 1, 1, 0, 32'h0, 4'b0000, M_ALL, "R1");
    busCycle(1, 0, 0, 1, 0, 32'hABCD1234, 4'b0000, M_ALL, "R3");
    idle("R7");
    busCycle(0, 1, 1, 1, 1, 32'h000A0100, 4'b0111, M_ALL, "R9");
    idle("R7");
    @(negedge clk);
    @(negedge clk);
    check("R8", "queue drained", expQ.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule